// File: doc/BRIEF.md
# Display Power Mode and Rail Sequencer

This block controls a display power supply that has two internal DC-DC converters (an inverting converter and a positive boost converter) and four switched output rails. Rail 0 is the negative LDO together with the common-electrode driver. Rail 1 is the negative charge pump, rail 2 the positive LDO and rail 3 the positive charge pump. A host drives one wake-up pin and four edge-sensitive request pins, one per rail. The block turns those into converter and rail enables and reports whether the supply is in SLEEP, STANDBY or ACTIVE.

All five host inputs pass through two-flop synchronizers before edge detection, and all timing counts a one-microsecond tick input. The first rail brought up from STANDBY waits for the converters. The inverting converter starts first, and the boost converter starts once the inverting converter reports power-good. Each converter has a start-up timeout, and a timeout drops the supply back to STANDBY.

Normally each rail follows its own request pin. If two rising request edges come closer than a set guard time, the block instead grants rails one at a time in the fixed order 0, 1, 2, 3, and each rail waits for the one before it to be ready. Dropping the wake-up pin while rails are on walks them down from the highest index, with a fixed gap between steps, before the block enters SLEEP.

Top module: `disp_pwr_seq`

## Requirements
- R1: While the synchronized wake-up level is low the block is in SLEEP: mode_o = 2'b00, no rail or converter enable is set, and request pin changes are ignored.
- R2: A wake-up rise with all request pins low enters STANDBY (mode_o = 2'b01), and no enable is set.
- R3: A wake-up rise with any request pin high enters ACTIVE (mode_o = 2'b10) and queues every request that is high.
- R4: On leaving STANDBY or SLEEP, the inverting converter enable rises first. The boost converter enable rises only after the inverting converter power-good. No rail enable is set before the boost converter power-good.
- R5: rail_rdy_o[i] rises RDY_US ticks after rail_en_o[i] rises, and it clears with the enable.
- R6: Request bit i drives rail_en_o[i]: 0 is the negative LDO with the common-electrode driver, 1 the negative charge pump, 2 the positive LDO and 3 the positive charge pump.
- R7: A rising request edge at least GAP_US ticks after the previous one enables its rail at once, once the converters are up, without waiting for other rails to be ready.
- R8: Rising edges less than GAP_US ticks apart (or in the same cycle) stagger the grants in order 0, 1, 2, 3, with each grant waiting until every enabled rail is ready.
- R9: A falling request edge disables its rail, and pins that fall in the same cycle disable their rails in the same cycle.
- R10: When no rail is enabled or pending in ACTIVE, the block returns to STANDBY and both converters switch off.
- R11: If a converter does not report power-good within TMO_US ticks of its enable, the block enters STANDBY with all enables cleared. Pins that are still high re-enable nothing until they are toggled.
- R12: A wake-up fall in ACTIVE disables the rails from the highest index down, one every DOWN_US ticks, and then enters SLEEP. A wake-up fall in STANDBY enters SLEEP directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| wake_i | input | 1 | Asynchronous wake-up pin |
| req_i | input | 4 | Asynchronous rail request pins |
| neg_pg_i | input | 1 | Inverting converter power-good |
| pos_pg_i | input | 1 | Boost converter power-good |
| mode_o | output | 2 | 00 SLEEP, 01 STANDBY, 10 ACTIVE |
| neg_conv_en_o | output | 1 | Inverting converter enable |
| pos_conv_en_o | output | 1 | Boost converter enable |
| rail_en_o | output | 4 | Rail enables, bit i for request i |
| rail_rdy_o | output | 4 | Rail ready flags |

## Verification
The bench builds the block with RDY_US=20, GAP_US=10, TMO_US=40 and DOWN_US=5, and it holds tick_i high every cycle. Scaled down this way, the rail ready delay, the close-edge stagger chain, the converter timeout and the stepped power-down each complete in tens of cycles. That lets every waveform be sampled with a few cycles of margin. A simple power-good model in the bench answers the converter enables after eight cycles and can be held off to force the timeout.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'b00,
    ST_STBY  = 2'b01,
    ST_ACT   = 2'b10,
    ST_DOWN  = 2'b11
  } seq_st_e;

  typedef enum logic [1:0] {
    CV_OFF = 2'b00,
    CV_NEG = 2'b01,
    CV_POS = 2'b10,
    CV_UP  = 2'b11
  } conv_st_e;
endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/dps_conv_ctrl.sv
module dps_conv_ctrl
  import dps_pkg::*;
#(
  parameter int TMO_US = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic neg_pg_i,
  input  logic pos_pg_i,
  output logic neg_en_o,
  output logic pos_en_o,
  output logic up_o,
  output logic fail_o
);
  localparam int CW = $clog2(TMO_US + 1);

  conv_st_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic expired;

  assign expired = (cnt_q >= CW'(TMO_US));
  assign fail_o  = run_i && ((st_q == CV_NEG && !neg_pg_i && expired) ||
                             (st_q == CV_POS && !pos_pg_i && expired));

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      CV_OFF: if (run_i) begin st_n = CV_NEG; cnt_n = '0; end
      CV_NEG: begin
        if (!run_i || fail_o) st_n = CV_OFF;
        else if (neg_pg_i) begin st_n = CV_POS; cnt_n = '0; end
        else if (tick_i) cnt_n = cnt_q + 1'b1;
      end
      CV_POS: begin
        if (!run_i || fail_o) st_n = CV_OFF;
        else if (pos_pg_i) st_n = CV_UP;
        else if (tick_i) cnt_n = cnt_q + 1'b1;
      end
      default: if (!run_i) st_n = CV_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CV_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign neg_en_o = (st_q != CV_OFF);
  assign pos_en_o = (st_q == CV_POS) || (st_q == CV_UP);
  assign up_o     = (st_q == CV_UP);

  // R4
  pos_after_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_en_o) |-> $past(neg_pg_i));
endmodule

// File: rtl/dps_rail_timer.sv
module dps_rail_timer #(
  parameter int RDY_US = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  output logic rdy_o
);
  localparam int TW = $clog2(RDY_US + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      rdy_o <= 1'b0;
    end else if (tick_i && !rdy_o) begin
      if (cnt_q == TW'(RDY_US - 1)) rdy_o <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  rdy_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(en_i));
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dps_pkg::*;
#(
  parameter int N_RAIL  = 4,
  parameter int RDY_US  = 2000,
  parameter int GAP_US  = 63,
  parameter int TMO_US  = 10000,
  parameter int DOWN_US = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wake_i,
  input  logic [N_RAIL-1:0] req_i,
  input  logic              neg_pg_i,
  input  logic              pos_pg_i,
  output logic [1:0]        mode_o,
  output logic              neg_conv_en_o,
  output logic              pos_conv_en_o,
  output logic [N_RAIL-1:0] rail_en_o,
  output logic [N_RAIL-1:0] rail_rdy_o
);
  localparam int GW = $clog2(GAP_US + 1);
  localparam int DW = $clog2(DOWN_US + 1);

  logic              wake_lvl;
  logic              wake_rise_unused, wake_fall_unused;
  logic [N_RAIL-1:0] req_lvl, rise, fall;
  logic [N_RAIL-1:0] rdy;
  logic              conv_run, conv_up, conv_fail;

  seq_st_e           st_q, st_n;
  logic [N_RAIL-1:0] pend_q, pend_n, en_q, en_n;
  logic              stag_q, stag_n;
  logic [DW-1:0]     dcnt_q, dcnt_n;
  logic [GW-1:0]     gap_q;
  logic              hist_q;
  logic              close;

  dps_sync #(.W(1)) u_wake_sync (
    .clk_i, .rst_ni, .d_i(wake_i), .lvl_o(wake_lvl),
    .rise_o(wake_rise_unused), .fall_o(wake_fall_unused)
  );

  dps_sync #(.W(N_RAIL)) u_req_sync (
    .clk_i, .rst_ni, .d_i(req_i), .lvl_o(req_lvl), .rise_o(rise), .fall_o(fall)
  );

  assign conv_run = (st_q == ST_ACT) || (st_q == ST_DOWN);

  dps_conv_ctrl #(.TMO_US(TMO_US)) u_conv (
    .clk_i, .rst_ni, .tick_i, .run_i(conv_run),
    .neg_pg_i, .pos_pg_i,
    .neg_en_o(neg_conv_en_o), .pos_en_o(pos_conv_en_o),
    .up_o(conv_up), .fail_o(conv_fail)
  );

  for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
    dps_rail_timer #(.RDY_US(RDY_US)) u_tmr (
      .clk_i, .rst_ni, .tick_i, .en_i(en_q[i]), .rdy_o(rdy[i])
    );
  end

  function automatic logic [N_RAIL-1:0] low_bit(input logic [N_RAIL-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [N_RAIL-1:0] high_bit(input logic [N_RAIL-1:0] v);
    logic [N_RAIL-1:0] r;
    r = '0;
    for (int i = 0; i < N_RAIL; i++)
      if (v[i]) r = N_RAIL'(1) << i;
    return r;
  endfunction

  // two rising edges inside the guard window force staggering
  assign close = (|rise) && (($countones(rise) > 1) || (hist_q && (gap_q < GW'(GAP_US))));

  always_comb begin
    st_n   = st_q;
    pend_n = pend_q;
    en_n   = en_q;
    stag_n = stag_q;
    dcnt_n = dcnt_q;
    case (st_q)
      ST_SLEEP: begin
        pend_n = '0;
        en_n   = '0;
        stag_n = 1'b0;
        if (wake_lvl) begin
          if (|req_lvl) begin
            st_n   = ST_ACT;
            pend_n = req_lvl;
            stag_n = ($countones(req_lvl) > 1);
          end else begin
            st_n = ST_STBY;
          end
        end
      end
      ST_STBY: begin
        pend_n = '0;
        en_n   = '0;
        if (!wake_lvl) st_n = ST_SLEEP;
        else if (|rise) begin
          st_n   = ST_ACT;
          pend_n = rise;
          stag_n = close;
        end
      end
      ST_ACT: begin
        if (!wake_lvl) begin
          st_n   = ST_DOWN;
          pend_n = '0;
          dcnt_n = '0;
        end else if (conv_fail) begin
          st_n   = ST_STBY;
          pend_n = '0;
          en_n   = '0;
          stag_n = 1'b0;
        end else begin
          pend_n = (pend_q | rise) & ~fall;
          en_n   = en_q & ~fall;
          stag_n = stag_q | close;
          if (conv_up) begin
            if (!stag_n) begin
              en_n   = en_n | pend_n;
              pend_n = '0;
            end else if ((en_n & ~rdy) == '0) begin
              en_n   = en_n | low_bit(pend_n);
              pend_n = pend_n & ~low_bit(pend_n);
            end
          end
          if (pend_n == '0) stag_n = 1'b0;
          if (en_n == '0 && pend_n == '0) st_n = ST_STBY;
        end
      end
      default: begin
        pend_n = '0;
        stag_n = 1'b0;
        if (en_q == '0) st_n = ST_SLEEP;
        else if (tick_i) begin
          if (dcnt_q == DW'(DOWN_US - 1)) begin
            en_n   = en_q & ~high_bit(en_q);
            dcnt_n = '0;
          end else begin
            dcnt_n = dcnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SLEEP;
      pend_q <= '0;
      en_q   <= '0;
      stag_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      en_q   <= en_n;
      stag_q <= stag_n;
      dcnt_q <= dcnt_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      hist_q <= 1'b0;
    end else if (st_q == ST_SLEEP) begin
      gap_q  <= '0;
      hist_q <= 1'b0;
    end else if (|rise) begin
      gap_q  <= '0;
      hist_q <= 1'b1;
    end else if (tick_i && gap_q < GW'(GAP_US)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign mode_o     = (st_q == ST_DOWN) ? 2'(ST_ACT) : 2'(st_q);
  assign rail_en_o  = en_q;
  assign rail_rdy_o = rdy;

  // R4
  rail_needs_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != '0) |-> (conv_up && pos_conv_en_o));

  // R1
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && $past(st_q == ST_SLEEP)) |-> (en_q == '0 && !neg_conv_en_o));

  // R8
  stagger_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stag_q |-> ($countones(en_q & ~$past(en_q)) <= 1));

  // R12
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DOWN && $past(st_q == ST_DOWN)) |->
      (($countones($past(en_q) & ~en_q) <= 1) && ((en_q & ~$past(en_q)) == '0)));

  // R11
  fail_to_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_fail |=> (st_q == ST_STBY && en_q == '0));
endmodule

// File: tb/disp_pwr_seq_tb.sv
module disp_pwr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wake = 1'b0;
  logic [3:0] req = 4'b0;
  logic       hold_neg = 1'b0;
  logic [7:0] nc, pc;
  logic       neg_pg, pos_pg;
  logic [1:0] mode;
  logic       neg_en, pos_en;
  logic [3:0] rail_en, rail_rdy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_pwr_seq #(
    .N_RAIL(4), .RDY_US(20), .GAP_US(10), .TMO_US(40), .DOWN_US(5)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .wake_i(wake), .req_i(req),
    .neg_pg_i(neg_pg), .pos_pg_i(pos_pg), .mode_o(mode),
    .neg_conv_en_o(neg_en), .pos_conv_en_o(pos_en),
    .rail_en_o(rail_en), .rail_rdy_o(rail_rdy)
  );

  // converter model: power-good eight cycles after enable
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nc <= '0;
      pc <= '0;
    end else begin
      nc <= neg_en ? ((nc == 8'hff) ? nc : nc + 1'b1) : '0;
      pc <= pos_en ? ((pc == 8'hff) ? pc : pc + 1'b1) : '0;
    end
  end
  assign neg_pg = neg_en && (nc >= 8) && !hold_neg;
  assign pos_pg = pos_en && (pc >= 8);

  typedef struct packed {
    logic       wake;
    logic [3:0] req;
    logic [7:0] wait_c;
    logic [1:0] mode;
    logic [3:0] en;
    logic [3:0] rdy;
    logic [3:0] rid;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{1'b0, 4'b0000, 8'd10, 2'b00, 4'b0000, 4'b0000, 4'd1},  // R1 asleep
    '{1'b0, 4'b0100, 8'd10, 2'b00, 4'b0000, 4'b0000, 4'd1},  // R1 request ignored
    '{1'b0, 4'b0000, 8'd5,  2'b00, 4'b0000, 4'b0000, 4'd1},
    '{1'b1, 4'b0000, 8'd10, 2'b01, 4'b0000, 4'b0000, 4'd2},  // R2
    '{1'b1, 4'b0001, 8'd60, 2'b10, 4'b0001, 4'b0001, 4'd6},  // R6 R5
    '{1'b1, 4'b0101, 8'd30, 2'b10, 4'b0101, 4'b0101, 4'd7},  // R7
    '{1'b1, 4'b0111, 8'd5,  2'b10, 4'b0111, 4'b0101, 4'd7},  // R7 no wait for ready
    '{1'b1, 4'b0111, 8'd30, 2'b10, 4'b0111, 4'b0111, 4'd5},  // R5
    '{1'b1, 4'b0011, 8'd10, 2'b10, 4'b0011, 4'b0011, 4'd9},  // R9
    '{1'b1, 4'b0000, 8'd10, 2'b01, 4'b0000, 4'b0000, 4'd10}, // R9 R10
    '{1'b1, 4'b1111, 8'd30, 2'b10, 4'b0001, 4'b0000, 4'd8},  // R8 first
    '{1'b1, 4'b1111, 8'd20, 2'b10, 4'b0011, 4'b0001, 4'd8},  // R8 second
    '{1'b1, 4'b1111, 8'd40, 2'b10, 4'b1111, 4'b0111, 4'd8},  // R8 chain
    '{1'b1, 4'b1111, 8'd30, 2'b10, 4'b1111, 4'b1111, 4'd8},
    '{1'b0, 4'b1111, 8'd4,  2'b10, 4'b1111, 4'b1111, 4'd12}, // R12 start
    '{1'b0, 4'b1111, 8'd5,  2'b10, 4'b0111, 4'b0111, 4'd12}, // R12 highest first
    '{1'b0, 4'b1111, 8'd5,  2'b10, 4'b0011, 4'b0011, 4'd12},
    '{1'b0, 4'b1111, 8'd20, 2'b00, 4'b0000, 4'b0000, 4'd12}  // R12 sleep
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset mode", 8'(mode), 8'h0);
    chk("R1 reset rails", 8'(rail_en), 8'h0);
    chk("R1 reset conv", 8'({neg_en, pos_en}), 8'h0);
    rst_n = 1'b1;
    wait_n(2);

    for (int i = 0; i < 18; i++) begin
      wake = VEC[i].wake;
      req  = VEC[i].req;
      wait_n(int'(VEC[i].wait_c));
      chk($sformatf("R%0d vec%0d mode", VEC[i].rid, i), 8'(mode), 8'(VEC[i].mode));
      chk($sformatf("R%0d vec%0d en", VEC[i].rid, i), 8'(rail_en), 8'(VEC[i].en));
      chk($sformatf("R%0d vec%0d rdy", VEC[i].rid, i), 8'(rail_rdy), 8'(VEC[i].rdy));
    end

    // R3: wake rise with a request already high
    req = 4'b0001;
    wait_n(5);
    wake = 1'b1;
    wait_n(5);
    chk("R3 mode", 8'(mode), 8'h2);
    wait_n(60);
    chk("R3 rail", 8'(rail_en), 8'h1);
    req = 4'b0000;
    wait_n(10);
    chk("R10 standby", 8'(mode), 8'h1);
    chk("R10 conv off", 8'({neg_en, pos_en}), 8'h0);

    // R11: converter timeout
    hold_neg = 1'b1;
    req = 4'b0010;
    wait_n(20);
    chk("R11 starting", 8'(mode), 8'h2);
    wait_n(40);
    chk("R11 mode", 8'(mode), 8'h1);
    chk("R11 conv", 8'({neg_en, pos_en}), 8'h0);
    chk("R11 rails", 8'(rail_en), 8'h0);
    hold_neg = 1'b0;
    wait_n(20);
    chk("R11 held pin ignored", 8'({mode, rail_en}), 8'h10);
    req = 4'b0000;
    wait_n(5);

    // R4: converter order
    req = 4'b0010;
    wait_n(8);
    chk("R4 neg only", 8'({neg_en, pos_en}), 8'h2);
    chk("R4 no rail early", 8'(rail_en), 8'h0);
    wait_n(10);
    chk("R4 both conv", 8'({neg_en, pos_en}), 8'h3);
    chk("R4 rail waits", 8'(rail_en), 8'h0);
    wait_n(42);
    chk("R6 rail1", 8'(rail_en), 8'h2);
    chk("R5 rail1 rdy", 8'(rail_rdy), 8'h2);
    req = 4'b0000;
    wait_n(5);
    chk("R10 back to standby", 8'({mode, neg_en, pos_en}), 8'h4);
    wake = 1'b0;
    wait_n(5);
    chk("R12 standby to sleep", 8'(mode), 8'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule